// File: doc/BRIEF.md
# Static Link Chain Walker

This block finds the base address of an enclosing activation record a chosen number of lexical levels above the current one. It starts from the current base pointer. For each level it reads the word stored at the working base, which is that record's static link, and makes it the new working base. When the requested number of hops is done, it returns the final base together with a one-cycle completion strobe.

The walker drives a single read port of the stack RAM. The RAM answers a request after a fixed number of cycles, `RD_LAT`. A level count of zero completes at once with the start base and reads nothing. A link that points outside the stack aborts the walk and flags an error. Choosing the level count and using the returned base belong to the surrounding processor.

Top module: `scope_base_walker`

## Requirements
- R1: After reset, `done_o`, `error_o` and `mem_rd_en_o` are low and `base_o` is zero.
- R2: A start with a level count n > 0, accepted while idle, issues its first read at address `cur_base_i`.
- R3: A start with level count 0 sets `done_o` on the very edge that samples it. `base_o` becomes `cur_base_i`, `error_o` stays low and no read is issued.
- R4: Each hop reads the working base address. The returned word becomes the next working base, using its low `ADDR_W` bits.
- R5: For a walk that makes k reads, `done_o` is set by the edge k×(1+`RD_LAT`) edges after the edge that samples `start_i`.
- R6: `done_o` is high for one cycle per walk. `base_o` holds the result until the next completion.
- R7: A walk of n levels without error issues exactly n reads. `mem_rd_en_o` is never high in two consecutive cycles.
- R8: `start_i` is ignored while a walk is in progress. The running walk's result, timing and read count are unchanged, and no extra completion follows.
- R9: A fetched word whose full unsigned value is ≥ `STACK_DEPTH` aborts the walk at once. `done_o` and `error_o` pulse together, `base_o` is the last valid working base, and no further read is issued. A value of `STACK_DEPTH`-1 is valid.
- R10: `error_o` is never high without `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a walk (sampled only while idle) |
| levels_i | input | CNT_W | Number of static links to follow |
| cur_base_i | input | ADDR_W | Current base pointer |
| done_o | output | 1 | One-cycle completion strobe |
| error_o | output | 1 | Walk aborted on an out-of-range link (with `done_o`) |
| base_o | output | ADDR_W | Resulting base address |
| mem_rd_en_o | output | 1 | Stack RAM read request |
| mem_rd_addr_o | output | ADDR_W | Stack RAM read address |
| mem_rd_data_i | input | DATA_W | Stack RAM read data, valid RD_LAT cycles after the request |

## Verification
The embedded assertions check, on every cycle:
- `error_o` only appears with `done_o`;
- a read request never lasts two cycles;
- the latency counter stays in bounds;
- an accepted hop decrements the remaining count by one;
- a zero-level start completes on the next cycle with the start base.

Only the bench's scenarios can show the following, because they need an independent model of the stack contents:
- the final base after a chain of pointer chasing;
- the exact completion cycle for k reads;
- the abort point on a bad link;
- the invisibility of a start issued mid-walk.

// File: rtl/scope_walk_pkg.sv
// Package: shared types for the static link chain walker.
// Assumes: nothing; holds only the controller state encoding.
package scope_walk_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,   // waiting for a start request
        WK_REQ  = 2'd1,   // read request on the RAM port this cycle
        WK_WAIT = 2'd2    // waiting for read data to return
    } walk_state_t;

endpackage

// File: rtl/swk_lat_timer.sv
// Module: swk_lat_timer
// Counts the cycles since a read request and flags the cycle in which
// the RAM data is valid (RD_LAT cycles after the request cycle).
// Assumes: RD_LAT >= 1; a new launch never arrives before data returns.
module swk_lat_timer #(
    parameter int RD_LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic data_valid_o
);
    localparam int LW = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);
    localparam logic [LW-1:0] LAT_V = LW'(RD_LAT);

    logic [LW-1:0] lat_cnt;

    // Purpose: advance the latency count from launch to data-valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (launch_i) begin
            lat_cnt <= LW'(1);
        end else if (lat_cnt == LAT_V) begin
            lat_cnt <= '0;
        end else if (lat_cnt != '0) begin
            lat_cnt <= lat_cnt + LW'(1);
        end
    end

    assign data_valid_o = (lat_cnt == LAT_V);

    // R7: the counter never passes the configured latency
    assert_lat_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cnt <= LAT_V);

endmodule

// File: rtl/swk_range_check.sv
// Module: swk_range_check
// Decides whether a fetched static link addresses a word inside the stack.
// Assumes: the stack occupies addresses 0 .. STACK_DEPTH-1.
module swk_range_check #(
    parameter int DATA_W      = 16,
    parameter int STACK_DEPTH = 1000
) (
    input  logic [DATA_W-1:0] link_i,
    output logic              link_ok_o
);
    localparam logic [DATA_W-1:0] LIMIT = DATA_W'(STACK_DEPTH);

    // Purpose: compare the full unsigned word against the stack size.
    always_comb begin
        link_ok_o = (link_i < LIMIT);
    end

endmodule

// File: rtl/swk_walk_fsm.sv
// Module: swk_walk_fsm
// Control of the walk: latches the start base and level count, issues
// one read per level, replaces the working base with each fetched link,
// and reports the final base (or an abort) with a one-cycle done.
// Assumes: data_valid_i marks the RAM response to the last request;
// link_ok_i qualifies rd_data_i in that cycle.
module swk_walk_fsm
    import scope_walk_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  levels_i,
    input  logic [ADDR_W-1:0] cur_base_i,
    input  logic              data_valid_i,
    input  logic              link_ok_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              done_o,
    output logic              error_o,
    output logic [ADDR_W-1:0] base_o
);
    walk_state_t       state;
    logic [ADDR_W-1:0] work_base;
    logic [CNT_W-1:0]  remain;
    logic [ADDR_W-1:0] link;

    assign link = rd_data_i[ADDR_W-1:0];

    // Purpose: sequence the walk and register the result and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WK_IDLE;
            work_base <= '0;
            remain    <= '0;
            done_o    <= 1'b0;
            error_o   <= 1'b0;
            base_o    <= '0;
        end else begin
            done_o  <= 1'b0;
            error_o <= 1'b0;
            case (state)
                WK_IDLE: begin
                    if (start_i) begin
                        work_base <= cur_base_i;
                        remain    <= levels_i;
                        if (levels_i == '0) begin
                            done_o <= 1'b1;
                            base_o <= cur_base_i;
                        end else begin
                            state <= WK_REQ;
                        end
                    end
                end
                WK_REQ: begin
                    state <= WK_WAIT;
                end
                WK_WAIT: begin
                    if (data_valid_i) begin
                        if (!link_ok_i) begin
                            done_o  <= 1'b1;
                            error_o <= 1'b1;
                            base_o  <= work_base;
                            state   <= WK_IDLE;
                        end else begin
                            work_base <= link;
                            remain    <= remain - CNT_W'(1);
                            if (remain == CNT_W'(1)) begin
                                done_o <= 1'b1;
                                base_o <= link;
                                state  <= WK_IDLE;
                            end else begin
                                state <= WK_REQ;
                            end
                        end
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    // Purpose: drive the RAM read port from the request state.
    always_comb begin
        rd_en_o   = (state == WK_REQ);
        rd_addr_o = work_base;
    end

    // R10: an error is only reported together with completion
    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    // R7: a read request lasts exactly one cycle
    assert_single_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);

    // R3: a zero-level start completes next cycle with the start base
    assert_zero_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WK_IDLE && start_i && levels_i == '0) |=>
        (done_o && !error_o && base_o == $past(cur_base_i)));

    // R4: each accepted hop consumes exactly one level
    assert_hop_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WK_WAIT && data_valid_i && link_ok_i) |=>
        (remain == $past(remain) - CNT_W'(1)));

endmodule

// File: rtl/scope_base_walker.sv
// Module: scope_base_walker (top)
// Follows a chain of static links in stack RAM to find the base of the
// activation record a given number of levels above the current one.
// Assumes: the stack RAM answers every read after exactly RD_LAT cycles,
// and cur_base_i lies inside the stack.
module scope_base_walker #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 4,
    parameter int STACK_DEPTH = 1000,
    parameter int RD_LAT      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  levels_i,
    input  logic [ADDR_W-1:0] cur_base_i,
    output logic              done_o,
    output logic              error_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [DATA_W-1:0] mem_rd_data_i
);
    logic data_valid;
    logic link_ok;

    swk_lat_timer #(.RD_LAT(RD_LAT)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (mem_rd_en_o),
        .data_valid_o (data_valid)
    );

    swk_range_check #(.DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH)) u_range (
        .link_i    (mem_rd_data_i),
        .link_ok_o (link_ok)
    );

    swk_walk_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .levels_i     (levels_i),
        .cur_base_i   (cur_base_i),
        .data_valid_i (data_valid),
        .link_ok_i    (link_ok),
        .rd_data_i    (mem_rd_data_i),
        .rd_en_o      (mem_rd_en_o),
        .rd_addr_o    (mem_rd_addr_o),
        .done_o       (done_o),
        .error_o      (error_o),
        .base_o       (base_o)
    );

endmodule

// File: tb/scope_base_walker_test.sv
module scope_base_walker_test;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 4;
    localparam int DEPTH  = 1000;
    localparam int LAT    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0]  levels = '0;
    logic [ADDR_W-1:0] cur_base = '0;
    logic done, err, rd_en;
    logic [ADDR_W-1:0] base, rd_addr;
    logic [DATA_W-1:0] rd_data;

    logic [DATA_W-1:0] mem [0:DEPTH-1];
    logic [DATA_W-1:0] pipe [0:LAT-1];
    int checks = 0;
    int errors = 0;
    int read_cnt = 0;
    int first_addr = -1;
    int prev_rd = 0;

    always #4 clk = ~clk;

    scope_base_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                        .STACK_DEPTH(DEPTH), .RD_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .levels_i(levels),
        .cur_base_i(cur_base), .done_o(done), .error_o(err), .base_o(base),
        .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data));

    // RAM model with LAT register stages
    always_ff @(posedge clk) begin
        pipe[0] <= (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign rd_data = pipe[LAT-1];

    // read observer at the port
    always @(posedge clk) begin
        if (rd_en) begin
            read_cnt <= read_cnt + 1;
            if (first_addr < 0) first_addr <= int'(rd_addr);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model(input int bp, input int n,
                                  output int b, output int e, output int r);
        b = bp; e = 0; r = 0;
        for (int i = 0; i < n; i++) begin
            r++;
            if (int'(mem[b]) >= DEPTH) begin e = 1; return; end
            b = int'(mem[b]);
        end
    endfunction

    task automatic walk(input int bp, input int n, input bit inject);
        int eb, ee, er, cyc, got_b, got_e, got_rd, xcyc;
        model(bp, n, eb, ee, er);
        xcyc = er * (1 + LAT) + 1;
        @(negedge clk);
        read_cnt = 0; first_addr = -1;
        start = 1'b1; levels = CNT_W'(n); cur_base = ADDR_W'(bp);
        @(negedge clk);
        cyc = 1;
        start = 1'b0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 2) begin
                start = 1'b1; levels = CNT_W'(0); cur_base = ADDR_W'((bp + 7) % DEPTH);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        got_b = int'(base); got_e = int'(err); got_rd = read_cnt;
        check(got_b == eb, ee ? "R9 abort base" : "R4 result base", got_b, eb);
        check(got_e == ee, ee ? "R9 error flag" : "R10 no error", got_e, ee);
        check(cyc == xcyc, "R5 completion cycle", cyc, xcyc);
        check(got_rd == er, "R7 read count", got_rd, er);
        if (n > 0) check(first_addr == bp, "R2 first read address", first_addr, bp);
        else check(got_rd == 0, "R3 no read on zero level", got_rd, 0);
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
        check(int'(base) == eb, "R6 base held", int'(base), eb);
        if (inject) begin
            repeat (4) begin
                @(negedge clk);
                check(done == 1'b0, "R8 no extra completion", int'(done), 0);
            end
            check(read_cnt == er, "R8 read count unchanged", read_cnt, er);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'($urandom % DEPTH);
        for (int i = 0; i < LAT; i++) pipe[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0 && err == 1'b0, "R1 strobes low in reset", int'(done) + int'(err), 0);
        check(rd_en == 1'b0, "R1 no read in reset", int'(rd_en), 0);
        check(base == '0, "R1 base zero", int'(base), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        walk(123, 0, 1'b0);                          // R3 zero level
        mem[10] = 16'd20; mem[20] = 16'd999; mem[999] = 16'd30;
        walk(10, 1, 1'b0);                           // R4 single hop
        walk(10, 3, 1'b0);                           // R4 boundary link DEPTH-1 valid
        mem[40] = 16'(DEPTH);                        // R9 exact limit invalid
        walk(40, 2, 1'b0);
        mem[50] = 16'd60; mem[60] = 16'hFFFF;        // R9 abort mid-walk
        walk(50, 5, 1'b0);
        walk(200, 15, 1'b0);                         // max level count
        walk(300, 4, 1'b1);                          // R8 start during walk

        // constrained random walks
        for (int k = 0; k < 60; k++) begin
            int bp, n, bad;
            logic [DATA_W-1:0] saved;
            bp = int'($urandom % DEPTH);
            n  = int'($urandom % 16);
            bad = int'($urandom % DEPTH);
            saved = mem[bad];
            if (($urandom % 6) == 0) mem[bad] = DATA_W'(DEPTH + ($urandom % 100));
            walk(bp, n, ($urandom % 5) == 0 && n > 0);
            mem[bad] = saved;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule